// File: doc/BRIEF.md
# Key Debouncer with Two-Stage Auto-Repeat

This block turns one raw, active-high push-button signal into clean key events. The raw input first crosses a two-flop synchroniser. All decisions are then taken only on cycles where a 1 ms clock-enable `tick` is high. The block offers two acceptance styles, chosen by `mode_validated`.

- **Immediate mode (`mode_validated` = 0):** the first pressed sample produces an event on that very tick. A lockout interval follows, during which the key is not looked at.
- **Validated mode (`mode_validated` = 1):** an event is produced only after an unbroken run of pressed samples.

In both modes, a key that stays held produces auto-repeat events. A long first delay comes first, then a shorter repeat period. Once the key is released, it must stay released for a qualification interval before a new press is accepted. Every interval is a parameter counted in ticks.

The controller has six named states:

| State | Meaning |
|---|---|
| ST_IDLE | Waiting for a press |
| ST_CONFIRM | Counting consecutive pressed samples (validated mode) |
| ST_LOCKOUT | Key ignored after an immediate-mode event |
| ST_DELAY | Key held; counting the first repeat delay |
| ST_REPEAT | Key held; counting the repeat period |
| ST_RELQUAL | Counting consecutive released samples |

The transitions, all taken on a tick, are:

| Transition | From | To | Condition on the tick |
|---|---|---|---|
| fast_accept | ST_IDLE | ST_LOCKOUT | Pressed sample, immediate mode |
| start_confirm | ST_IDLE | ST_CONFIRM | Pressed sample, validated mode |
| confirm_abort | ST_CONFIRM | ST_IDLE | Released sample |
| confirm_done | ST_CONFIRM | ST_DELAY | CONFIRM_TICKS-th consecutive pressed sample |
| lock_held | ST_LOCKOUT | ST_DELAY | Last lockout tick, key pressed |
| lock_free | ST_LOCKOUT | ST_RELQUAL | Last lockout tick, key released |
| first_repeat | ST_DELAY | ST_REPEAT | Delay expires, key pressed |
| next_repeat | ST_REPEAT | ST_REPEAT | Period expires, key pressed |
| let_go | ST_DELAY or ST_REPEAT | ST_RELQUAL | Released sample |
| requalified | ST_RELQUAL | ST_IDLE | Enough consecutive released samples |

Outputs:

- `press_pulse` is combinational from the state register and the synchronised key. It is high for exactly the tick cycle on which an event is issued.
- `repeat_flag` is high with it when the event is a repeat.
- `key_level` is the debounced level. It is high in ST_LOCKOUT, ST_DELAY and ST_REPEAT.

CONFIRM_TICKS, RELEASE_TICKS, FIRST_DELAY_TICKS and REPEAT_TICKS must each be at least 2. LOCKOUT_TICKS must be at least 1.

Top module: `key_repeat_debouncer`

## Requirements
- R1: The raw key reaches the decision logic only through two clock-edge flops. A change on `key_raw` made in the same cycle as a tick has no effect on that tick.
- R2: In immediate mode, from ST_IDLE, the first tick that sees the key pressed raises `press_pulse` in that same tick cycle, with `repeat_flag` low. `key_level` is high from the next cycle.
- R3: After an immediate event, the next LOCKOUT_TICKS ticks ignore the key and `key_level` stays high. On the last of them, the key decides the next step: held goes to the repeat delay, released goes to release qualification.
- R4: After a release, a new press is accepted only after RELEASE_TICKS consecutive released ticks, not counting the release tick itself. Any pressed tick before that restarts the count and issues no event.
- R5: In validated mode, `press_pulse` is issued on the CONFIRM_TICKS-th consecutive pressed tick. `key_level` stays low until then.
- R6: In validated mode, a released tick during confirmation returns the block to ST_IDLE. The next press starts the count again from one.
- R7: While the key stays held after acceptance (validated mode) or after the lockout (immediate mode), the first repeat event comes on the FIRST_DELAY_TICKS-th held tick. Further repeats come every REPEAT_TICKS held ticks.
- R8: Each repeat event raises `press_pulse` and `repeat_flag` together with `key_level` high. An acceptance event has `repeat_flag` low and `key_level` still low in that cycle.
- R9: A released tick in the held states cancels any pending repeat. `key_level` falls in the next cycle, and no event is issued while the key is released.
- R10: `mode_validated` is looked at only in ST_IDLE. Changing it while a press is in progress changes neither the current acceptance nor its repeats.
- R11: While reset is asserted, and just after it, `press_pulse`, `repeat_flag` and `key_level` are low.
- R12: `press_pulse` is never high in a cycle without `tick`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle clock enable, nominally every 1 ms |
| key_raw | input | 1 | Raw key, high when pressed |
| mode_validated | input | 1 | 0: immediate mode with lockout, 1: validated mode |
| press_pulse | output | 1 | One-cycle event strobe for acceptance or repeat |
| repeat_flag | output | 1 | High with `press_pulse` when the event is a repeat |
| key_level | output | 1 | Debounced key level |

## Verification
A wrong state or a miscounted interval shows at the ports in one of three ways: an event lands on the wrong tick, an extra event appears, or an expected event is missing. Each of these becomes visible within one tick of the intended decision point. The bench therefore sweeps the hold length tick by tick in both modes, against closed-form counts of acceptances and repeats. A state stuck in the held group, or released from it too early, shows as a wrong `key_level` right after the hold. It also shows as stray events during the following release window. Bounce patterns during lockout, confirmation and release qualification each expose a counter that fails to restart within one tick.

// File: rtl/kd_pkg.sv
package kd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CONFIRM,
        ST_LOCKOUT,
        ST_DELAY,
        ST_REPEAT,
        ST_RELQUAL
    } kd_state_t;

    function automatic int kd_max(input int a, input int b);
        return (a > b) ? a : b;
    endfunction
endpackage

// File: rtl/kd_sync.sv
module kd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_in,
    output logic d_out
);
    logic [STAGES-1:0] chain;

    always_ff @(posedge clk) begin
        if (!rst_n) chain <= '0;
        else        chain <= {chain[STAGES-2:0], d_in};
    end

    assign d_out = chain[STAGES-1];
endmodule

// File: rtl/kd_interval_counter.sv
module kd_interval_counter #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    always_ff @(posedge clk) begin
        if (!rst_n)   count <= '0;
        else if (clr) count <= inc ? W'(1) : '0;
        else if (inc) count <= count + W'(1);
    end
endmodule

// File: rtl/key_repeat_debouncer.sv
module key_repeat_debouncer
    import kd_pkg::*;
#(
    parameter int CONFIRM_TICKS     = 40,
    parameter int LOCKOUT_TICKS     = 100,
    parameter int RELEASE_TICKS     = 50,
    parameter int FIRST_DELAY_TICKS = 500,
    parameter int REPEAT_TICKS      = 100
) (
    input  logic clk,
    input  logic rst_n,
    input  logic tick,
    input  logic key_raw,
    input  logic mode_validated,
    output logic press_pulse,
    output logic repeat_flag,
    output logic key_level
);
    localparam int MAX_A = kd_max(CONFIRM_TICKS, LOCKOUT_TICKS);
    localparam int MAX_B = kd_max(RELEASE_TICKS, FIRST_DELAY_TICKS);
    localparam int MAX_T = kd_max(kd_max(MAX_A, MAX_B), REPEAT_TICKS);
    localparam int CW    = $clog2(MAX_T + 1);

    localparam logic [CW-1:0] LAST_CONF = CW'(CONFIRM_TICKS - 1);
    localparam logic [CW-1:0] LAST_LOCK = CW'(LOCKOUT_TICKS - 1);
    localparam logic [CW-1:0] LAST_REL  = CW'(RELEASE_TICKS - 1);
    localparam logic [CW-1:0] LAST_DLY  = CW'(FIRST_DELAY_TICKS - 1);
    localparam logic [CW-1:0] LAST_REP  = CW'(REPEAT_TICKS - 1);

    kd_state_t     state, nxt;
    logic          key_s;
    logic          cnt_clr, cnt_inc;
    logic [CW-1:0] cnt;

    kd_sync #(.STAGES(2)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_in  (key_raw),
        .d_out (key_s)
    );

    kd_interval_counter #(.W(CW)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (cnt_clr),
        .inc   (cnt_inc),
        .count (cnt)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next state and interval counter control
    always_comb begin
        nxt     = state;
        cnt_clr = 1'b0;
        cnt_inc = 1'b0;
        if (tick) begin
            unique case (state)
                ST_IDLE: begin
                    cnt_clr = 1'b1;
                    if (key_s) begin
                        cnt_inc = mode_validated;
                        nxt     = mode_validated ? ST_CONFIRM : ST_LOCKOUT;
                    end
                end
                ST_CONFIRM: begin
                    if (!key_s) begin
                        nxt     = ST_IDLE;
                        cnt_clr = 1'b1;
                    end else if (cnt == LAST_CONF) begin
                        nxt     = ST_DELAY;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_LOCKOUT: begin
                    if (cnt == LAST_LOCK) begin
                        cnt_clr = 1'b1;
                        nxt     = key_s ? ST_DELAY : ST_RELQUAL;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_DELAY: begin
                    if (!key_s) begin
                        nxt     = ST_RELQUAL;
                        cnt_clr = 1'b1;
                    end else if (cnt == LAST_DLY) begin
                        nxt     = ST_REPEAT;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_REPEAT: begin
                    if (!key_s) begin
                        nxt     = ST_RELQUAL;
                        cnt_clr = 1'b1;
                    end else if (cnt == LAST_REP) begin
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                ST_RELQUAL: begin
                    if (key_s) begin
                        cnt_clr = 1'b1;
                    end else if (cnt == LAST_REL) begin
                        nxt     = ST_IDLE;
                        cnt_clr = 1'b1;
                    end else begin
                        cnt_inc = 1'b1;
                    end
                end
                default: begin
                    nxt     = ST_IDLE;
                    cnt_clr = 1'b1;
                end
            endcase
        end
    end

    // Outputs
    always_comb begin
        press_pulse = 1'b0;
        repeat_flag = 1'b0;
        key_level   = 1'b0;
        unique case (state)
            ST_IDLE:    press_pulse = tick && key_s && !mode_validated;
            ST_CONFIRM: press_pulse = tick && key_s && (cnt == LAST_CONF);
            ST_LOCKOUT: key_level   = 1'b1;
            ST_DELAY: begin
                key_level   = 1'b1;
                repeat_flag = tick && key_s && (cnt == LAST_DLY);
                press_pulse = repeat_flag;
            end
            ST_REPEAT: begin
                key_level   = 1'b1;
                repeat_flag = tick && key_s && (cnt == LAST_REP);
                press_pulse = repeat_flag;
            end
            ST_RELQUAL: key_level = 1'b0;
            default:    key_level = 1'b0;
        endcase
    end
endmodule

// File: rtl/kd_checker.sv
module kd_checker (
    input logic clk,
    input logic rst_n,
    input logic tick,
    input logic press_pulse,
    input logic repeat_flag,
    input logic key_level
);
    assert_pulse_on_tick_R12: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |-> tick);

    assert_repeat_marked_R8: assert property (@(posedge clk) disable iff (!rst_n)
        repeat_flag |-> (press_pulse && key_level));

    assert_accept_from_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (press_pulse && !repeat_flag) |-> !key_level);

    assert_pulse_leaves_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
        press_pulse |=> key_level);

    assert_rise_needs_accept_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(key_level) |-> $past(press_pulse && !repeat_flag));

    assert_fall_on_tick_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_level) |-> $past(tick));
endmodule

bind key_repeat_debouncer kd_checker u_kd_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .tick        (tick),
    .press_pulse (press_pulse),
    .repeat_flag (repeat_flag),
    .key_level   (key_level)
);

// File: tb/key_repeat_debouncer_test.sv
module key_repeat_debouncer_test;
    localparam int CLK_PERIOD = 10;
    localparam int C  = 4;
    localparam int LK = 5;
    localparam int RL = 3;
    localparam int D  = 6;
    localparam int R  = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic tick = 1'b0;
    logic key_raw = 1'b0;
    logic mode_validated = 1'b0;
    logic press_pulse, repeat_flag, key_level;

    int total = 0;
    int bad = 0;
    int n_press, n_rep, first_at, tick_no;
    bit finished = 1'b0;

    key_repeat_debouncer #(
        .CONFIRM_TICKS(C), .LOCKOUT_TICKS(LK), .RELEASE_TICKS(RL),
        .FIRST_DELAY_TICKS(D), .REPEAT_TICKS(R)
    ) uut (
        .clk(clk), .rst_n(rst_n), .tick(tick), .key_raw(key_raw),
        .mode_validated(mode_validated), .press_pulse(press_pulse),
        .repeat_flag(repeat_flag), .key_level(key_level)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic start_run();
        n_press = 0; n_rep = 0; first_at = -1; tick_no = 0;
    endtask

    task automatic tick_once(input bit k);
        key_raw = k;
        repeat (3) @(posedge clk);
        @(negedge clk);
        tick = 1'b1;
        #1;
        tick_no++;
        if (press_pulse) begin
            n_press++;
            if (first_at < 0) first_at = tick_no;
        end
        if (repeat_flag) n_rep++;
        @(posedge clk);
        #1 tick = 1'b0;
    endtask

    task automatic settle(input string tag);
        start_run();
        for (int i = 0; i < LK + RL + 2; i++) tick_once(1'b0);
        chk({tag, " no events while released"}, n_press, 0);
        chk({tag, " level low after release"}, int'(key_level), 0);
    endtask

    task automatic finish_up();
        if (!finished) begin
            finished = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        total++; bad++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_up();
    end

    initial begin
        int acc, reps, first;
        int lvl_ok;

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        chk("R11 pulse in reset", int'(press_pulse), 0);
        chk("R11 level in reset", int'(key_level), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk("R11 repeat after reset", int'(repeat_flag), 0);
        chk("R11 level after reset", int'(key_level), 0);

        // R1: raw change in tick cycle is not seen
        mode_validated = 1'b0;
        @(negedge clk);
        key_raw = 1'b1; tick = 1'b1;
        #1;
        chk("R1 unsynchronised press ignored", int'(press_pulse), 0);
        @(posedge clk); #1 tick = 1'b0;
        start_run();
        tick_once(1'b1);
        chk("R1 synchronised press seen", n_press, 1);
        settle("R1");

        // Sweep hold length in both modes
        for (int m = 0; m < 2; m++) begin
            for (int h = 1; h <= 20; h++) begin
                mode_validated = m[0];
                start_run();
                for (int i = 0; i < h; i++) tick_once(1'b1);
                if (m == 0) begin
                    acc = 1; first = 1;
                    reps = (h >= 1 + LK + D) ? 1 + (h - 1 - LK - D) / R : 0;
                    chk("R2 immediate acceptance tick", first_at, first);
                    chk("R2 level held", int'(key_level), 1);
                end else begin
                    acc = (h >= C) ? 1 : 0; first = acc ? C : -1;
                    reps = (h >= C + D) ? 1 + (h - C - D) / R : 0;
                    chk("R5 validated acceptance tick", first_at, first);
                    chk("R5 level after hold", int'(key_level), acc);
                end
                chk("R7 repeat count", n_rep, reps);
                chk("R8 acceptance count", n_press - n_rep, acc);
                settle("R9");
            end
        end

        // R3: bounce during lockout ignored
        mode_validated = 1'b0;
        start_run();
        tick_once(1'b1);
        lvl_ok = 1;
        for (int i = 0; i < LK - 1; i++) begin
            tick_once(i[0]);
            if (key_level !== 1'b1) lvl_ok = 0;
        end
        chk("R3 level high through lockout", lvl_ok, 1);
        tick_once(1'b0);
        chk("R3 single event despite bounce", n_press, 1);
        chk("R3 released at lockout end", int'(key_level), 0);

        // R4: release qualification restarts on press
        start_run();
        for (int i = 0; i < RL - 1; i++) tick_once(1'b0);
        for (int i = 0; i < 4; i++) tick_once(1'b1);
        chk("R4 early press rejected", n_press, 0);
        chk("R4 level stays low", int'(key_level), 0);
        for (int i = 0; i < RL; i++) tick_once(1'b0);
        tick_once(1'b1);
        chk("R4 press after qualification", n_press, 1);
        chk("R4 event tick", first_at, 4 + RL - 1 + RL + 1);
        settle("R4");

        // R6: released sample restarts confirmation
        mode_validated = 1'b1;
        start_run();
        for (int i = 0; i < C - 1; i++) tick_once(1'b1);
        tick_once(1'b0);
        for (int i = 0; i < C - 1; i++) tick_once(1'b1);
        chk("R6 no event before full run", n_press, 0);
        tick_once(1'b1);
        chk("R6 event after restarted run", first_at, 2 * C);
        settle("R6");

        // R10: mode change mid-press has no effect
        mode_validated = 1'b1;
        start_run();
        tick_once(1'b1);
        tick_once(1'b1);
        mode_validated = 1'b0;
        for (int i = 0; i < C + D - 2; i++) tick_once(1'b1);
        chk("R10 acceptance stays validated", first_at, C);
        chk("R10 repeat timing unchanged", n_rep, 1);
        settle("R10");
        start_run();
        tick_once(1'b1);
        mode_validated = 1'b1;
        for (int i = 0; i < 3; i++) tick_once(1'b1);
        chk("R10 new mode used at next press", first_at, 1);
        chk("R10 lockout not turned into confirm", n_press, 1);
        settle("R10");

        finish_up();
    end
endmodule